// File: doc/BRIEF.md
# Eight-Bit Timer with Clear-on-Compare

This block is an 8-bit up-counter that advances on a one-cycle tick from a selectable clock divider. In free-running operation it counts from zero to its maximum value and wraps. In clear-on-compare operation a compare register sets the top of the count: the counter returns to zero on the tick that follows an equal value. This makes the compare value the period control.

Each compare match sets a sticky match flag. Each step from the maximum value back to zero sets a sticky overflow flag. Both flags go out as plain outputs to an external interrupt controller. A waveform output can invert on every match, which gives a square wave at f_clk / (2·N·(1+compare)).

Software uses a small write port to load the counter, the compare value and a control byte, and to clear the flags. The compare register has no shadow copy. A write takes effect in the next cycle, so a compare value written below the current count is not seen until the counter has wrapped through zero.

Top module: `cmpclr_timer`

## Requirements
- R1: After a synchronous reset the count, compare value, control byte, both flags and the waveform output are all zero.
- R2: The control byte at address 2 holds the clock select in bits [2:0]. Select 0 stops counting. Selects 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 cycles: a tick occurs when the low log2(N) bits of a free 10-bit cycle counter, cleared by reset, are all ones. Selects 6 and 7 also stop counting.
- R3: When the mode field (control bits [4:3]) is 0, each tick adds one to the count, and 0xFF steps to 0x00.
- R4: When the mode field is 2, a tick that finds the count equal to the compare value loads zero instead of adding one.
- R5: A write to address 1 replaces the compare value in the next cycle, with no buffering. If the new value is below the count, no match occurs until the count has wrapped through 0x00 and climbed back to the compare value.
- R6: A match (a tick with the count equal to the compare value) sets the match flag. The flag stays set until a write to address 3 with data bit 0 set. When a match and that clear fall in the same cycle, the flag ends up set.
- R7: A tick that finds the count at 0xFF sets the overflow flag, in every mode. The flag stays set until a write to address 3 with data bit 1 set, and a set in the same cycle as the clear wins.
- R8: When the output-mode field (control bits [6:5]) is 1, the waveform output inverts on every match. For any other value of the field it holds its level.
- R9: A write to address 0 loads the count in the next cycle and overrides counting in that cycle. No match is taken in that cycle or on the next tick.
- R10: Mode values 1 and 3 behave as mode 0: the count runs through a compare value without clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 count, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current count |
| cmp_flag_o | output | 1 | Sticky compare-match flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| wave_o | output | 1 | Waveform output |

## Verification
The bench builds the block with its default 8-bit count and 10-bit divider. With these values, wraps at 0xFF and the full 1024-cycle divide both fall within a short run. The fast selects let the random phase reach many matches, overflows and flag-clear collisions. Directed cases cover the stopped clock, a compare value of zero with toggling, a compare value written below the count, a counter write that lands on the compare value, and the spare mode codes.

// File: rtl/cmpclr_timer_pkg.sv
package cmpclr_timer_pkg;

    localparam int unsigned CNT_W_DEF = 8;
    localparam int unsigned PRE_W_DEF = 10;

    typedef enum logic [1:0] {
        ADDR_COUNT   = 2'd0,
        ADDR_COMPARE = 2'd1,
        ADDR_CONTROL = 2'd2,
        ADDR_FLAGCLR = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'd0,
        MODE_SPARE1  = 2'd1,
        MODE_CMPCLR  = 2'd2,
        MODE_SPARE3  = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        OUT_HOLD     = 2'd0,
        OUT_TOGGLE   = 2'd1,
        OUT_SPARE2   = 2'd2,
        OUT_SPARE3   = 2'd3
    } out_mode_e;

    typedef struct packed {
        out_mode_e   omode;
        run_mode_e   mode;
        logic [2:0]  csel;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    // log2 of the divide factor for each clock select; -1 marks a stopped clock
    function automatic int csel_shift(input logic [2:0] sel);
        case (sel)
            3'd1:    return 0;
            3'd2:    return 3;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 10;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/cmpclr_timer_prescale.sv
module cmpclr_timer_prescale
    import cmpclr_timer_pkg::*;
#(
    parameter int unsigned PRE_W = PRE_W_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  csel,
    output logic        tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    int               shift;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        shift = csel_shift(csel);
        mask  = '0;
        for (int b = 0; b < PRE_W; b++) begin
            if (b < shift) mask[b] = 1'b1;
        end
        tick  = (shift >= 0) && ((pre_q & mask) == mask);
    end

endmodule

// File: rtl/cmpclr_timer_core.sv
module cmpclr_timer_core
    import cmpclr_timer_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             clr_on_match,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit,
    output logic             wrap
);

    logic [CNT_W-1:0] cmp_q;
    logic             blk_q;   // a loaded count skips one match

    always_comb begin
        hit  = tick && !cnt_wr && !blk_q && (cnt_q == cmp_q);
        wrap = tick && !cnt_wr && (cnt_q == {CNT_W{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cmp_q <= '0;
            blk_q <= 1'b0;
        end else begin
            if (cnt_wr) begin
                cnt_q <= wr_data;
                blk_q <= 1'b1;
            end else if (tick) begin
                cnt_q <= (hit && clr_on_match) ? '0 : cnt_q + 1'b1;
                blk_q <= 1'b0;
            end
            if (cmp_wr) cmp_q <= wr_data;
        end
    end

endmodule

// File: rtl/cmpclr_timer_events.sv
module cmpclr_timer_events (
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       wrap,
    input  logic [1:0] clr,
    input  logic       toggle_en,
    output logic [1:0] flags,
    output logic       wave
);

    logic [1:0] set_v;
    assign set_v = {wrap, hit};

    for (genvar i = 0; i < 2; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flags[i] <= 1'b0;
            else     flags[i] <= (flags[i] & ~clr[i]) | set_v[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   wave <= 1'b0;
        else if (hit && toggle_en) wave <= ~wave;
    end

endmodule

// File: rtl/cmpclr_timer.sv
module cmpclr_timer
    import cmpclr_timer_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF,
    parameter int unsigned PRE_W = PRE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             cmp_flag_o,
    output logic             ovf_flag_o,
    output logic             wave_o
);

    ctrl_t      ctrl_q;
    logic       cnt_wr, cmp_wr, ctl_wr, clr_wr;
    logic [1:0] flag_clr;
    logic [1:0] flags;
    logic       tick, hit, wrap;

    always_comb begin
        cnt_wr   = wr_en && (reg_addr_e'(wr_addr) == ADDR_COUNT);
        cmp_wr   = wr_en && (reg_addr_e'(wr_addr) == ADDR_COMPARE);
        ctl_wr   = wr_en && (reg_addr_e'(wr_addr) == ADDR_CONTROL);
        clr_wr   = wr_en && (reg_addr_e'(wr_addr) == ADDR_FLAGCLR);
        flag_clr = {2{clr_wr}} & wr_data[1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= '0;
        else if (ctl_wr) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    cmpclr_timer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .csel (ctrl_q.csel),
        .tick (tick)
    );

    cmpclr_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .cnt_wr       (cnt_wr),
        .cmp_wr       (cmp_wr),
        .wr_data      (wr_data),
        .clr_on_match (ctrl_q.mode == MODE_CMPCLR),
        .cnt_q        (count_o),
        .hit          (hit),
        .wrap         (wrap)
    );

    cmpclr_timer_events u_evt (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .wrap      (wrap),
        .clr       (flag_clr),
        .toggle_en (ctrl_q.omode == OUT_TOGGLE),
        .flags     (flags),
        .wave      (wave_o)
    );

    assign cmp_flag_o = flags[0];
    assign ovf_flag_o = flags[1];

endmodule

// File: rtl/cmpclr_timer_chk.sv
module cmpclr_timer_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             hit,
    input logic             cnt_wr,
    input logic [1:0]       mode,
    input logic [2:0]       csel,
    input logic [1:0]       flag_clr,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count_o,
    input logic             cmp_flag_o,
    input logic             ovf_flag_o,
    input logic             wave_o
);

    // R4: a match in clear-on-compare mode returns the count to zero
    a_r4_match_clears: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == 2'd2) |=> (count_o == '0));

    // R7: stepping off the top value raises the overflow flag
    a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && count_o == {CNT_W{1'b1}}) |=> ovf_flag_o);

    // R7: the overflow flag only falls through a clear write
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag_o && !flag_clr[1]) |=> ovf_flag_o);

    // R6: a match always leaves the match flag set
    a_r6_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
        hit |=> cmp_flag_o);

    // R8: the waveform moves only on a match
    a_r8_wave_only_on_hit: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(wave_o));

    // R2: a stopped clock freezes the count
    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (csel == 3'd0 && !cnt_wr) |=> $stable(count_o));

    // R9: a counter write lands on the next cycle regardless of ticks
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count_o == $past(wr_data)));

endmodule

bind cmpclr_timer cmpclr_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .hit        (hit),
    .cnt_wr     (cnt_wr),
    .mode       (ctrl_q.mode),
    .csel       (ctrl_q.csel),
    .flag_clr   (flag_clr),
    .wr_data    (wr_data),
    .count_o    (count_o),
    .cmp_flag_o (cmp_flag_o),
    .ovf_flag_o (ovf_flag_o),
    .wave_o     (wave_o)
);

// File: tb/cmpclr_timer_tb_top.sv
`timescale 1ns/1ps
module cmpclr_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count_o;
    logic       cmp_flag_o, ovf_flag_o, wave_o;

    int vectors = 0;
    int errors  = 0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    cmpclr_timer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .cmp_flag_o(cmp_flag_o),
        .ovf_flag_o(ovf_flag_o), .wave_o(wave_o)
    );

    // ---------------- reference model built from the requirements ----------
    logic [7:0] m_cnt, m_cmp, m_ctl;
    logic [9:0] m_pre;
    logic       m_blk, m_fm, m_fo, m_wave;

    function automatic bit ref_tick(input logic [2:0] sel, input logic [9:0] pre);
        int n;
        case (sel)
            3'd1: n = 1;   3'd2: n = 8;   3'd3: n = 64;
            3'd4: n = 256; 3'd5: n = 1024;
            default: n = 0;
        endcase
        if (n == 0) return 1'b0;
        return (int'(pre) % n) == (n - 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_cmp = 0; m_ctl = 0; m_pre = 0;
            m_blk = 0; m_fm = 0; m_fo = 0; m_wave = 0;
        end else begin
            bit tk, wc, mt, ov;
            tk = ref_tick(m_ctl[2:0], m_pre);
            wc = wr_en && wr_addr == 2'd0;
            mt = tk && !wc && !m_blk && m_cnt == m_cmp;
            ov = tk && !wc && m_cnt == 8'hFF;
            if (wc) begin m_cnt = wr_data; m_blk = 1; end
            else if (tk) begin
                m_cnt = (mt && m_ctl[4:3] == 2'd2) ? 8'h00 : m_cnt + 8'd1;
                m_blk = 0;
            end
            m_fm = (m_fm & ~(wr_en && wr_addr == 2'd3 && wr_data[0])) | mt;
            m_fo = (m_fo & ~(wr_en && wr_addr == 2'd3 && wr_data[1])) | ov;
            if (mt && m_ctl[6:5] == 2'd1) m_wave = ~m_wave;
            if (wr_en && wr_addr == 2'd1) m_cmp = wr_data;
            if (wr_en && wr_addr == 2'd2) m_ctl = {1'b0, wr_data[6:0]};
            m_pre = m_pre + 10'd1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(count_o == m_cnt, "R3 R4 R5 R9 count", count_o, m_cnt);
            check(cmp_flag_o == m_fm, "R6 match flag", cmp_flag_o, m_fm);
            check(ovf_flag_o == m_fo, "R7 overflow flag", ovf_flag_o, m_fo);
            check(wave_o == m_wave, "R8 wave", wave_o, m_wave);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired (R1 run incomplete)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic w0;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        started = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(count_o == 0 && !cmp_flag_o && !ovf_flag_o && !wave_o,
              "R1 reset state", {count_o, cmp_flag_o, ovf_flag_o, wave_o}, 0);

        // R2: stopped clock keeps a loaded count
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd5);
        idle(30);
        check(count_o == 8'd5, "R2 stopped clock", count_o, 5);

        // R2: divide by 8 in free mode
        wr(2'd2, 8'h02);
        idle(300);

        // R5: compare zero written while the count sits above it
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h31);          // toggle, clear-on-compare, N=1
        idle(100);
        check(!cmp_flag_o, "R5 missed compare before wrap", cmp_flag_o, 0);
        idle(200);
        check(count_o == 8'd0, "R4 top of zero holds count", count_o, 0);
        w0 = wave_o;
        @(negedge clk);
        check(wave_o != w0, "R8 toggle every cycle", wave_o, !w0);

        // R6: clear collides with a match each cycle -> set wins
        wr(2'd3, 8'h01);
        check(cmp_flag_o, "R6 set beats clear", cmp_flag_o, 1);

        // R9: load the compare value -> no clear on the next tick
        wr(2'd2, 8'h11);
        wr(2'd1, 8'd10);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd10;
        @(negedge clk);
        wr_en = 1'b0;
        check(count_o == 8'd10, "R9 load lands", count_o, 10);
        @(negedge clk);
        check(count_o == 8'd11, "R9 match skipped after load", count_o, 11);

        // R10: spare mode 1 runs through the compare value
        wr(2'd2, 8'h09);
        wr(2'd1, 8'd3);
        wr(2'd0, 8'd0);
        idle(10);
        check(count_o > 8'd3, "R10 spare mode no clear", count_o, 4);
        wr(2'd3, 8'h03);

        // random phase
        for (int i = 0; i < 30000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                logic [1:0] a;
                logic [7:0] d;
                a = 2'($urandom_range(0, 3));
                d = 8'($urandom);
                if (a == 2'd2 && $urandom_range(0, 3) != 0)
                    d[2:0] = ($urandom_range(0, 1) != 0) ? 3'd1 : 3'd2;
                wr(a, d);
            end else begin
                @(negedge clk);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule